// File: doc/BRIEF.md
# Pixel-to-Bit-Plane Transposer

This block accepts a continuous stream of colour pixels, one pixel per clock, with an M-bit gray level for each of the red, green and blue channels. It collects N consecutive pixels into a bit matrix and then sends the group out as M bit planes. Each output word carries one bit of equal weight from every one of the N pixels, and each colour has its own output lane. Data that is spread across many pixels at once in this way is much harder to rebuild from the radiation of a parallel video cable than data sent one whole pixel at a time.

Each colour has two matrices that swap roles. While one matrix is filled a row at a time from the incoming pixels, the other is read a column at a time. The input therefore never waits. Because N is at least M, the M read cycles of one group always fit within the N write cycles of the next. Horizontal and vertical sync pass through a delay line whose length equals the latency of the video path, so the sync pulses leave the block at the same place relative to the picture as they entered it. A strobe marks the last plane of every group.

Top module: `pix_plane_xpose`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_done`, `out_hs`, `out_vs`, `out_r`, `out_g` and `out_b` are all 0 after that edge. The first pixel sampled after reset is released becomes pixel 0 of a new group.
- R2: Bit i of every output plane word comes from the i-th pixel of the group in arrival order. Pixel 0 lands in bit 0 and pixel N-1 in bit N-1.
- R3: Within a group, the p-th plane (p = 0 first) carries input bit M-1-p of every pixel. Planes therefore run from the most significant bit down to bit 0.
- R4: The three channels are converted independently and with the same timing. `out_r`, `out_g` and `out_b` carry only bits of `in_r`, `in_g` and `in_b` respectively.
- R5: If the first pixel of a group is sampled at clock edge E, plane p of that group is on the outputs in the cycle that follows edge E+N+p.
- R6: `out_valid` is high for exactly M consecutive cycles per group. It is low for the remaining N-M cycles of each N-cycle period.
- R7: `out_done` is high only in the cycle that carries the last plane (bit 0) of a group, and it is high in every such cycle.
- R8: A value of `in_hs` or `in_vs` sampled at edge E appears on `out_hs` or `out_vs` after edge E+N, which is the same delay as the video planes. Reset clears the delay line.
- R9: The block converts every group of an unbroken pixel stream correctly, including a group that is being written while the previous one is still being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_r | input | M | Red gray level of the current pixel |
| in_g | input | M | Green gray level of the current pixel |
| in_b | input | M | Blue gray level of the current pixel |
| in_hs | input | 1 | Horizontal sync, aligned with the input pixel |
| in_vs | input | 1 | Vertical sync, aligned with the input pixel |
| out_valid | output | 1 | A bit plane is present on the output lanes |
| out_r | output | N | Red bit plane, one bit per pixel |
| out_g | output | N | Green bit plane, one bit per pixel |
| out_b | output | N | Blue bit plane, one bit per pixel |
| out_done | output | 1 | Last plane of a group |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |

## Verification
The hardest situation to reach from the ports is the bank swap under load. In that case the last planes of one group are read from one matrix while the first pixels of the next group are already being written into the other, and the sync pulses must stay aligned across this overlap. The bench drives an unbroken stream of groups built from contrasting patterns: all zeros, all ones, walking bits in both directions, counts and scrambled values. Each colour gets a different transform of the pattern, so a swap, lane or channel error changes the plane words. The sync inputs follow periods that are not multiples of N, so the pulses cross group boundaries at many phases.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
  localparam int NCOL  = 3;
  localparam int IDX_R = 0;
  localparam int IDX_G = 1;
  localparam int IDX_B = 2;
endpackage

// File: rtl/pxp_row_ctrl.sv
// Write side: row counter, one-hot row enables and fill bank select.
module pxp_row_ctrl #(
  parameter int NPIX = 8,
  parameter int WW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  output logic [NPIX-1:0] row_we,
  output logic            wbank,
  output logic            wlast
);
  logic [WW-1:0] wcnt;

  assign wlast = (wcnt == WW'(NPIX-1));

  for (genvar i = 0; i < NPIX; i++) begin : g_dec
    assign row_we[i] = (wcnt == WW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt  <= '0;
      wbank <= 1'b0;
    end else if (wlast) begin
      wcnt  <= '0;
      wbank <= ~wbank;
    end else begin
      wcnt <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/pxp_col_ctrl.sv
// Read side: walks the columns of the bank that has just been filled.
module pxp_col_ctrl #(
  parameter int DEPTH = 8,
  parameter int RW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_bank,
  output logic          busy,
  output logic          rbank,
  output logic [RW-1:0] rcol,
  output logic          rlast
);
  assign rlast = busy && (rcol == RW'(DEPTH-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      rbank <= 1'b0;
      rcol  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      rbank <= start_bank;
      rcol  <= '0;
    end else if (busy) begin
      if (rlast) busy <= 1'b0;
      else       rcol <= rcol + 1'b1;
    end
  end
endmodule

// File: rtl/pxp_matrix.sv
// Two NPIX x DEPTH bit matrices for one colour: rows in, columns out.
module pxp_matrix #(
  parameter int NPIX  = 8,
  parameter int DEPTH = 8,
  parameter int RW    = 3
) (
  input  logic             clk,
  input  logic [NPIX-1:0]  row_we,
  input  logic             wbank,
  input  logic [DEPTH-1:0] pix,
  input  logic             rbank,
  input  logic [RW-1:0]    rcol,
  output logic [NPIX-1:0]  plane
);
  logic [DEPTH-1:0] bank0 [NPIX];
  logic [DEPTH-1:0] bank1 [NPIX];
  logic [DEPTH-1:0] rrow;

  // bit j of the pixel sits in column DEPTH-1-j, so column 0 holds the MSB
  always_comb begin
    for (int j = 0; j < DEPTH; j++) rrow[DEPTH-1-j] = pix[j];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPIX; i++) begin
      if (row_we[i]) begin
        if (wbank) bank1[i] <= rrow;
        else       bank0[i] <= rrow;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPIX; i++)
      plane[i] = rbank ? bank1[i][rcol] : bank0[i][rcol];
  end
endmodule

// File: rtl/pxp_sync_dly.sv
// Fixed-length shift register for the sync signals.
module pxp_sync_dly #(
  parameter int STAGES = 9,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] sr [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) sr[k] <= '0;
    end else begin
      sr[0] <= d;
      for (int k = 1; k < STAGES; k++) sr[k] <= sr[k-1];
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/pix_plane_xpose.sv
module pix_plane_xpose #(
  parameter int NPIX  = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] in_r,
  input  logic [DEPTH-1:0] in_g,
  input  logic [DEPTH-1:0] in_b,
  input  logic             in_hs,
  input  logic             in_vs,
  output logic             out_valid,
  output logic [NPIX-1:0]  out_r,
  output logic [NPIX-1:0]  out_g,
  output logic [NPIX-1:0]  out_b,
  output logic             out_done,
  output logic             out_hs,
  output logic             out_vs
);
  import pxp_pkg::*;

  localparam int WW  = $clog2(NPIX);
  localparam int RW  = $clog2(DEPTH);
  localparam int LAT = NPIX + 1;

  if (NPIX < DEPTH || DEPTH < 2) begin : g_bad_cfg
    $error("pix_plane_xpose needs NPIX >= DEPTH >= 2");
  end

  logic [NPIX-1:0]  row_we;
  logic             wbank, wlast;
  logic             rbusy, rbank, rlast;
  logic [RW-1:0]    rcol;
  logic [DEPTH-1:0] pix_in [NCOL];
  logic [NPIX-1:0]  plane  [NCOL];
  logic [1:0]       sync_q;

  assign pix_in[IDX_R] = in_r;
  assign pix_in[IDX_G] = in_g;
  assign pix_in[IDX_B] = in_b;

  pxp_row_ctrl #(.NPIX(NPIX), .WW(WW)) u_row (
    .clk(clk), .rst(rst), .row_we(row_we), .wbank(wbank), .wlast(wlast)
  );

  pxp_col_ctrl #(.DEPTH(DEPTH), .RW(RW)) u_col (
    .clk(clk), .rst(rst), .start(wlast), .start_bank(wbank),
    .busy(rbusy), .rbank(rbank), .rcol(rcol), .rlast(rlast)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_chan
    pxp_matrix #(.NPIX(NPIX), .DEPTH(DEPTH), .RW(RW)) u_mat (
      .clk(clk), .row_we(row_we), .wbank(wbank), .pix(pix_in[c]),
      .rbank(rbank), .rcol(rcol), .plane(plane[c])
    );
  end

  pxp_sync_dly #(.STAGES(LAT), .W(2)) u_sync (
    .clk(clk), .rst(rst), .d({in_hs, in_vs}), .q(sync_q)
  );

  assign out_hs = sync_q[1];
  assign out_vs = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_done  <= 1'b0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= rbusy;
      out_done  <= rlast;
      out_r     <= rbusy ? plane[IDX_R] : '0;
      out_g     <= rbusy ? plane[IDX_G] : '0;
      out_b     <= rbusy ? plane[IDX_B] : '0;
    end
  end
endmodule

// File: rtl/pxp_checker.sv
module pxp_checker #(
  parameter int NPIX  = 8,
  parameter int DEPTH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            out_valid,
  input logic            out_done,
  input logic [NPIX-1:0] row_we
);
  localparam int VW = $clog2(DEPTH + 1);

  // length of the current run of valid planes before this cycle
  logic [VW-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (rst || !out_valid || out_done) vcnt <= '0;
    else                               vcnt <= vcnt + 1'b1;
  end

  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_done |-> out_valid); // R7

  AST_DONE_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (vcnt == VW'(DEPTH-1))); // R6

  AST_RUN_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_done) |-> (vcnt < VW'(DEPTH-1))); // R6

  AST_ONE_ROW_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    $countones(row_we) == 1); // R2

  AST_DONE_THEN_RESTART: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done); // R7
endmodule

bind pix_plane_xpose pxp_checker #(.NPIX(NPIX), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_done(out_done), .row_we(row_we)
);

// File: tb/pix_plane_xpose_test.sv
module pix_plane_xpose_test;
  localparam int BN = 10;
  localparam int BM = 8;
  localparam int NGRP = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BM-1:0] in_r = '0, in_g = '0, in_b = '0;
  logic in_hs = 1'b0, in_vs = 1'b0;
  logic out_valid, out_done, out_hs, out_vs;
  logic [BN-1:0] out_r, out_g, out_b;

  always #10 clk = ~clk;

  pix_plane_xpose #(.NPIX(BN), .DEPTH(BM)) uut (
    .clk(clk), .rst(rst), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .in_hs(in_hs), .in_vs(in_vs), .out_valid(out_valid), .out_r(out_r),
    .out_g(out_g), .out_b(out_b), .out_done(out_done),
    .out_hs(out_hs), .out_vs(out_vs)
  );

  typedef struct {
    int            due;
    logic [BN-1:0] r, g, b;
    logic          done;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   ecount = 0;
  bit   mon_on = 0;
  bit   hs_hist [0:4095];
  bit   vs_hist [0:4095];

  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at edge %0d", tag, act, exp, ecount);
    end
  endtask

  function automatic logic [7:0] patt(input int g, input int i);
    case (g)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'(1 << (i % 8));
      3: return 8'(8'h80 >> (i % 8));
      4: return 8'(i * 37 + 5);
      5: return (i % 2 == 1) ? 8'h55 : 8'hAA;
      default: return (g < 12) ? 8'((g * 73 + i * 151 + 29) ^ (i << 3)) : 8'h00;
    endcase
  endfunction

  // drive one pixel at the current negedge, sampled at edge ecount+1
  task automatic drive_px(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    int e;
    e = ecount + 1;
    in_r = r; in_g = g; in_b = b;
    in_hs = ((e % 13) < 2);
    in_vs = ((e % 41) < 4);
    hs_hist[e] = in_hs;
    vs_hist[e] = in_vs;
    @(negedge clk);
  endtask

  task automatic drive_group(input int gi);
    logic [7:0] pr [BN];
    logic [7:0] pg [BN];
    logic [7:0] pb [BN];
    int e0;
    exp_t it;
    e0 = ecount + 1;
    for (int i = 0; i < BN; i++) begin
      logic [7:0] v;
      v = patt(gi, i);
      pr[i] = v;
      pg[i] = ~v;
      pb[i] = {v[3:0], v[7:4]} ^ 8'h3C;
      drive_px(pr[i], pg[i], pb[i]);
    end
    for (int p = 0; p < BM; p++) begin
      it.due = e0 + BN + p;
      for (int i = 0; i < BN; i++) begin
        it.r[i] = pr[i][BM-1-p];
        it.g[i] = pg[i][BM-1-p];
        it.b[i] = pb[i][BM-1-p];
      end
      it.done = (p == BM - 1);
      q.push_back(it);
    end
  endtask

  task automatic summary_and_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      int  e;
      bit  exp_v;
      e = ecount;
      exp_v = (q.size() > 0) && (q[0].due == e);
      chk("R5 R6 out_valid", 32'(out_valid), 32'(exp_v));
      if (exp_v) begin
        chk("R2 R3 R9 out_r plane", 32'(out_r), 32'(q[0].r));
        chk("R4 out_g plane", 32'(out_g), 32'(q[0].g));
        chk("R4 out_b plane", 32'(out_b), 32'(q[0].b));
        chk("R7 out_done", 32'(out_done), 32'(q[0].done));
        void'(q.pop_front());
      end else begin
        chk("R7 out_done idle", 32'(out_done), 32'd0);
      end
      chk("R8 out_hs", 32'(out_hs), (e >= BN) ? 32'(hs_hist[e-BN]) : 32'd0);
      chk("R8 out_vs", 32'(out_vs), (e >= BN) ? 32'(vs_hist[e-BN]) : 32'd0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 act=running exp=finished");
    summary_and_end();
  end

  initial begin
    for (int k = 0; k < 4096; k++) begin
      hs_hist[k] = 1'b0;
      vs_hist[k] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    chk("R1 reset done", 32'(out_done), 32'd0);
    chk("R1 reset planes", 32'(out_r | out_g | out_b), 32'd0);
    chk("R1 reset sync", 32'({out_hs, out_vs}), 32'd0);
    rst = 1'b0;
    mon_on = 1'b1;
    for (int g = 0; g < NGRP; g++) drive_group(g);
    while (q.size() > 0) drive_px(8'h00, 8'h00, 8'h00);
    mon_on = 1'b0;
    // reset in the middle of a fill: everything must clear
    in_hs = 1'b1; in_vs = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset valid", 32'(out_valid), 32'd0);
    chk("R1 mid reset planes", 32'(out_r | out_g | out_b), 32'd0);
    chk("R1 mid reset sync", 32'({out_hs, out_vs, out_done}), 32'd0);
    summary_and_end();
  end
endmodule